// File: doc/BRIEF.md
# IEC-958 Serial Transmitter

The transmitter takes 32-bit sub-frame words that software has already filled in and sends them on a single output line as a bi-phase-mark coded IEC-958 stream. One unit interval (UI), which is half of a bit cell, lasts exactly one clock cycle. A sub-frame is 32 bit slots, so it takes 64 cycles. The hardware adds only three things to what software supplies: the synchronisation preamble in slots 0 to 3, the parity bit in slot 31, and the line coding. Bits 4 to 30 of each word go out unchanged in the slot with the same number. Bits 0 to 3 and bit 31 of the word are discarded.

The block counts frames, with two sub-frames per frame and `FRAMES_PER_BLOCK` frames per block. From that count it picks the preamble of each sub-frame. It fetches one word per sub-frame through a valid/ready handshake. When no word is offered in time, it sends an all-zero sub-frame that still carries the correct preamble and parity, and it latches an underrun flag. A start-of-block strobe marks the first UI of every sub-frame that opens a block.

Top module: `sptx_top`

## Requirements
- R1: `word_ready_o` is high for exactly one cycle in every 64, in the last UI of the current sub-frame. The first such cycle is the first cycle after reset is released. A word is taken when `word_valid_i` is high in that cycle, and the line enters the new preamble on the following cycle.
- R2: Sub-frames alternate between first and second within each frame, and frames are numbered 0 to `FRAMES_PER_BLOCK`-1, after which the count wraps to 0. The first sub-frame of frame 0 carries preamble B, the first sub-frame of every other frame carries M, and every second sub-frame carries W.
- R3: Preambles take 8 UIs. Listed from the first UI, with a line level of 0 before them, they are B = 1,1,1,0,1,0,0,0, M = 1,1,1,0,0,0,1,0 and W = 1,1,1,0,0,1,0,0. When the level before them is 1, every UI is inverted.
- R4: Slot k (k = 4..30) carries bit k of the accepted word, coded as a cell of two UIs (UI 2k and 2k+1). The first UI inverts the UI before it. The second UI equals the first UI when the bit is 0 and is its inverse when the bit is 1.
- R5: Slot 31 carries a parity bit that makes the number of ones in slots 4 to 31 even. Word bits 0 to 3 and bit 31 have no effect on the output.
- R6: The line level in the last UI of every sub-frame equals the level before that sub-frame's preamble. After reset this level is always 0.
- R7: If `word_valid_i` is low in a ready cycle, the next sub-frame is sent as if the word were all zeros, and `underrun_o` goes high and stays high until reset.
- R8: `blk_start_o` is high only during the first UI of a sub-frame that carries preamble B.
- R9: While the synchronous reset is held, `ser_o`, `blk_start_o` and `underrun_o` are 0. The first sub-frame after reset carries preamble B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one UI per cycle |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | 32 | Sub-frame word; bit k feeds slot k for k = 4..30 |
| word_valid_i | input | 1 | A word is offered |
| word_ready_o | output | 1 | Word is taken in this cycle (last UI of the sub-frame) |
| ser_o | output | 1 | Bi-phase-mark coded serial line |
| blk_start_o | output | 1 | First UI of a block-opening sub-frame |
| underrun_o | output | 1 | Sticky: a sub-frame had no word |

## Verification
The bench builds the transmitter with `FRAMES_PER_BLOCK` = 3, so the frame counter wraps every six sub-frames. The B, M and W ordering and the wrap from the last frame back to B therefore recur many times in a short run. Every sub-frame is captured UI by UI and compared with a waveform that the bench derives on its own from the coding rules. The stimulus covers a walking one across all 32 word bits, so every data slot and every discarded bit is driven alone. Dense, sparse and pseudo-random words test parity, and scattered starved ready cycles exercise the underrun path.

// File: rtl/sptx_pkg.sv
package sptx_pkg;

  localparam int SUB_UI   = 64;
  localparam int PRE_UI   = 8;
  localparam int PAR_SLOT = 31;

  typedef logic [5:0] ui_t;

  typedef enum logic [1:0] {
    PRE_B = 2'd0,
    PRE_M = 2'd1,
    PRE_W = 2'd2
  } pre_kind_t;

  // Bit i of the result is UI i of the preamble.
  function automatic logic [7:0] pre_pattern(pre_kind_t kind, logic inv);
    logic [7:0] p;
    case (kind)
      PRE_M:   p = 8'b0100_0111;
      PRE_W:   p = 8'b0010_0111;
      default: p = 8'b0001_0111;
    endcase
    return inv ? ~p : p;
  endfunction

  // Even parity over the payload slots that are sent as supplied.
  function automatic logic sub_parity(logic [31:0] w);
    return ^w[30:4];
  endfunction

  // Next UI of a data cell, given the current line level.
  function automatic logic bmc_next(logic line_now, logic bit_v, logic second_half);
    return second_half ? (line_now ^ bit_v) : ~line_now;
  endfunction

endpackage

// File: rtl/sptx_slot_timer.sv
module sptx_slot_timer
  import sptx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output ui_t  ui_nxt_o,
  output logic load_o
);

  localparam ui_t LAST_UI = ui_t'(SUB_UI - 1);

  ui_t ui_q;

  assign load_o   = (ui_q == LAST_UI);
  assign ui_nxt_o = load_o ? '0 : ui_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) ui_q <= LAST_UI;
    else     ui_q <= ui_nxt_o;
  end

endmodule

// File: rtl/sptx_block_seq.sv
module sptx_block_seq
  import sptx_pkg::*;
#(
  parameter  int FRAMES = 192,
  localparam int FW     = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      adv_i,
  output pre_kind_t kind_o
);

  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

  logic          second_q;
  logic [FW-1:0] frame_q;

  always_comb begin
    if (second_q)             kind_o = PRE_W;
    else if (frame_q == '0)   kind_o = PRE_B;
    else                      kind_o = PRE_M;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q <= 1'b0;
      frame_q  <= '0;
    end else if (adv_i) begin
      second_q <= ~second_q;
      if (second_q)
        frame_q <= (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
    end
  end

endmodule

// File: rtl/sptx_word_latch.sv
module sptx_word_latch (
  input  logic        clk,
  input  logic        rst,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic        valid_i,
  output logic [31:0] word_o,
  output logic        underrun_o
);

  logic starve;

  assign starve = load_i & ~valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o     <= '0;
      underrun_o <= 1'b0;
    end else if (load_i) begin
      word_o <= valid_i ? word_i : '0;
      if (starve) underrun_o <= 1'b1;
    end
  end

endmodule

// File: rtl/sptx_bmc_enc.sv
module sptx_bmc_enc
  import sptx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load_i,
  input  ui_t         ui_nxt_i,
  input  pre_kind_t   kind_i,
  input  logic [31:0] word_i,
  output logic        ser_o,
  output logic        blk_start_o
);

  pre_kind_t  kind_q;
  logic       inv_q;
  logic       line_q;
  logic       blk_q;
  logic       line_d;
  logic [4:0] slot;
  logic       second_half;
  logic       slot_bit;
  logic [7:0] pre_now;
  logic [7:0] pre_first;

  assign slot        = ui_nxt_i[5:1];
  assign second_half = ui_nxt_i[0];
  assign slot_bit    = (slot == 5'(PAR_SLOT)) ? sub_parity(word_i) : word_i[slot];
  assign pre_now     = pre_pattern(kind_q, inv_q);
  assign pre_first   = pre_pattern(kind_i, line_q);

  always_comb begin
    if (load_i)                        line_d = pre_first[0];
    else if (ui_nxt_i < ui_t'(PRE_UI)) line_d = pre_now[ui_nxt_i[2:0]];
    else                               line_d = bmc_next(line_q, slot_bit, second_half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      kind_q <= PRE_B;
      inv_q  <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      blk_q  <= load_i && (kind_i == PRE_B);
      if (load_i) begin
        kind_q <= kind_i;
        inv_q  <= line_q;
      end
    end
  end

  assign ser_o       = line_q;
  assign blk_start_o = blk_q;

endmodule

// File: rtl/sptx_top.sv
module sptx_top
  import sptx_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] word_i,
  input  logic        word_valid_i,
  output logic        word_ready_o,
  output logic        ser_o,
  output logic        blk_start_o,
  output logic        underrun_o
);

  ui_t         ui_nxt;
  logic        load;
  pre_kind_t   kind_nxt;
  logic [31:0] cur_word;

  sptx_slot_timer u_timer (
    .clk      (clk),
    .rst      (rst),
    .ui_nxt_o (ui_nxt),
    .load_o   (load)
  );

  sptx_block_seq #(.FRAMES(FRAMES_PER_BLOCK)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (load),
    .kind_o (kind_nxt)
  );

  sptx_word_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .word_i     (word_i),
    .valid_i    (word_valid_i),
    .word_o     (cur_word),
    .underrun_o (underrun_o)
  );

  sptx_bmc_enc u_enc (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load),
    .ui_nxt_i    (ui_nxt),
    .kind_i      (kind_nxt),
    .word_i      (cur_word),
    .ser_o       (ser_o),
    .blk_start_o (blk_start_o)
  );

  assign word_ready_o = load & ~rst;

endmodule

// File: rtl/sptx_checks.sv
module sptx_checks (
  input logic clk,
  input logic rst,
  input logic word_valid_i,
  input logic word_ready_o,
  input logic ser_o,
  input logic blk_start_o,
  input logic underrun_o
);

  // Cycles since the last ready pulse; equals the UI index inside a sub-frame.
  logic [6:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (word_ready_o) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 7'h7f) begin
      gap  <= gap + 1'b1;
    end
  end

  p_ready_period_r1: assert property (@(posedge clk) disable iff (rst)
    seen |-> (word_ready_o == (gap == 7'd63)));

  p_preamble_opens_high_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && gap == 7'd0) |-> ser_o);

  // Next UI starts a data cell (slot 4..31): it must invert the current UI.
  p_cell_invert_r4: assert property (@(posedge clk) disable iff (rst)
    (seen && gap >= 7'd7 && gap <= 7'd61 && gap[0]) |=> (ser_o != $past(ser_o)));

  p_sub_end_level_r6: assert property (@(posedge clk) disable iff (rst)
    word_ready_o |-> !ser_o);

  p_underrun_set_r7: assert property (@(posedge clk) disable iff (rst)
    (word_ready_o && !word_valid_i) |=> underrun_o);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    underrun_o |=> underrun_o);

  p_blk_first_ui_r8: assert property (@(posedge clk) disable iff (rst)
    blk_start_o |-> (seen && gap == 7'd0 && ser_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_reset_quiet_r9: assert (!blk_start_o && !word_ready_o);
    end
  end

endmodule

bind sptx_top sptx_checks u_checks (
  .clk          (clk),
  .rst          (rst),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .ser_o        (ser_o),
  .blk_start_o  (blk_start_o),
  .underrun_o   (underrun_o)
);

// File: tb/tb_sptx_top.sv
`timescale 1ns/1ps
module tb_sptx_top;

  localparam int FR = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] word = '0;
  logic        valid = 1'b0;
  logic        ready, ser, blk, unr;

  always #2.5 clk = ~clk;

  sptx_top #(.FRAMES_PER_BLOCK(FR)) dut (
    .clk          (clk),
    .rst          (rst),
    .word_i       (word),
    .word_valid_i (valid),
    .word_ready_o (ready),
    .ser_o        (ser),
    .blk_start_o  (blk),
    .underrun_o   (unr)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  int   sub_no = 0;
  logic exp_lvl = 1'b0;
  bit   unr_seen = 1'b0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected 64-UI waveform (bit u = UI u) worked out from the coding rules.
  function automatic logic [63:0] model(int n, logic [31:0] w, logic prev);
    logic [63:0] wave;
    logic [7:0]  pat;
    logic        lvl;
    int          ones;
    logic        b;
    wave = '0;
    if (n % 2 == 1)            pat = 8'b11100100;
    else if ((n / 2) % FR == 0) pat = 8'b11101000;
    else                       pat = 8'b11100010;
    lvl = prev;
    for (int u = 0; u < 8; u++) begin
      lvl = pat[7-u] ^ prev;
      wave[u] = lvl;
    end
    ones = 0;
    for (int k = 4; k <= 30; k++) ones += w[k] ? 1 : 0;
    for (int s = 4; s <= 31; s++) begin
      b = (s == 31) ? logic'(ones % 2) : w[s];
      lvl = ~lvl;
      wave[2*s] = lvl;
      if (b) lvl = ~lvl;
      wave[2*s+1] = lvl;
    end
    return wave;
  endfunction

  // Entered at a falling edge inside a ready cycle.
  task automatic run_sub(input bit v, input logic [31:0] w);
    logic [63:0] got, rdy, bs, exp, exp_bs;
    check(ready === 1'b1, "R1 ready in last UI", 64'(ready), 64'd1);
    valid = v;
    word  = w;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    word  = ~w;
    for (int u = 0; u < 64; u++) begin
      got[u] = ser;
      rdy[u] = ready;
      bs[u]  = blk;
      if (u < 63) @(negedge clk);
    end
    exp = model(sub_no, v ? w : 32'd0, exp_lvl);
    exp_lvl = exp[63];
    check(got[7:0] === exp[7:0],
          (sub_no == 0) ? "R9 first preamble B" : "R2 R3 preamble", 64'(got[7:0]), 64'(exp[7:0]));
    check(got[61:8] === exp[61:8], "R4 data cells", 64'(got[61:8]), 64'(exp[61:8]));
    check(got[63:62] === exp[63:62], "R5 parity cell", 64'(got[63:62]), 64'(exp[63:62]));
    check(got[63] === 1'b0, "R6 end level", 64'(got[63]), 64'd0);
    check(rdy === 64'h8000_0000_0000_0000, "R1 ready pattern", rdy, 64'h8000_0000_0000_0000);
    exp_bs = (sub_no % 2 == 0 && (sub_no / 2) % FR == 0) ? 64'd1 : 64'd0;
    check(bs === exp_bs, "R8 block start", bs, exp_bs);
    if (!v) unr_seen = 1'b1;
    check(unr === unr_seen, "R7 underrun flag", 64'(unr), 64'(unr_seen));
    sub_no++;
  endtask

  initial begin
    logic [31:0] lcg;
    repeat (4) @(negedge clk);
    check(ser === 1'b0 && unr === 1'b0 && blk === 1'b0, "R9 reset outputs",
          64'({ser, unr, blk}), 64'd0);
    rst = 1'b0;
    #1;
    run_sub(1'b1, 32'h0000_0000);
    run_sub(1'b1, 32'hFFFF_FFFF);
    run_sub(1'b1, 32'hAAAA_AAAA);
    run_sub(1'b1, 32'h5555_5555);
    run_sub(1'b1, 32'h8000_000F);   // R5: only discarded bits set
    for (int k = 0; k < 32; k++) run_sub(1'b1, 32'd1 << k);
    run_sub(1'b0, 32'h1234_5678);   // R7: starved sub-frame
    run_sub(1'b1, 32'h0F0F_F0F0);
    lcg = 32'hC0FF_EE11;
    for (int i = 0; i < 30; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run_sub((i % 7) != 3, lcg);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule